// File: doc/BRIEF.md
# Dual-Target Interrupt Cause and Mask Controller

This block gathers 32 level-sensitive interrupt source lines and serves them to two processors. Each processor owns a cause register and a mask register. A cause register records which sources have been active since that processor last acknowledged them. A mask register selects which of those sources may raise that processor's interrupt line. A source that is high at a clock edge sets its bit in both cause registers. Each processor then clears its own copy by writing ones, so one processor's acknowledge never disturbs the other's view.

Software reaches the four registers over a plain 32-bit register bus with a write strobe, a read strobe, a byte address and write data. Read data is returned combinationally in the same cycle as the read strobe. For each target the block also drives an interrupt line and a status pair: the index of the lowest pending source, and a flag that is high when anything is pending for that target. Software services pending sources starting from the lowest index.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, both cause registers and both mask registers read 0, both interrupt outputs are low, and both valid flags are low.
- R2: The byte offsets are: 0x00 is target 0 cause, 0x04 is target 0 mask, 0x08 is target 1 cause, and 0x0C is target 1 mask. A read at any other offset returns 0, and a write at any other offset changes no register.
- R3: When source n is high at a clock edge, bit n of both cause registers is 1 after that edge, whatever the mask settings are.
- R4: Writing a word to a cause register clears each bit where the word has a 1 and leaves each bit where it has a 0. Such a write does not change the other target's cause register.
- R5: If a source is high in the same cycle that its cause bit is written with 1, the bit stays 1. Because sources are level-sensitive, a source that is still high after an acknowledge is pending again.
- R6: The interrupt output of a target is high exactly when its cause register ANDed with its mask register is non-zero.
- R7: The status index of a target gives the lowest bit position set in its cause AND mask. The valid flag is low when that set is empty.
- R8: Writing 0 to a target's mask register and then all ones to its cause register, with no source active, leaves that target with cause 0, its interrupt output low and its valid flag low.
- R9: A write to a mask register replaces the whole mask. A mask bit of 1 lets that source reach the target and a mask bit of 0 blocks it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt source lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when rd_en is low or the offset is unmapped |
| irq_o | output | 2 | Interrupt line per target, bit t is target t |
| tgt0_idx | output | 5 | Lowest pending source index for target 0 |
| tgt0_valid | output | 1 | Target 0 has at least one pending source |
| tgt1_idx | output | 5 | Lowest pending source index for target 1 |
| tgt1_valid | output | 1 | Target 1 has at least one pending source |

## Verification
The hardest case to reach from the ports is a source that is high in exactly the cycle in which software writes a 1 to clear its cause bit. The bench raises the source on a falling edge and keeps it high while it issues the acknowledge write. It then lowers the source and writes again, which shows both the set-over-clear result and the clear that follows. A second hard case is the divergence between the two cause copies. The bench pulses sources into both copies at once, acknowledges only one target, and then reads back both registers and both status pairs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [0:0] {
    REG_CAUSE = 1'b0,
    REG_MASK  = 1'b1
  } reg_kind_e;

  localparam int unsigned TGT_STRIDE = 8;
  localparam int unsigned MASK_SKEW  = 4;

  function automatic int unsigned reg_offset(input int unsigned tgt, input reg_kind_e kind);
    return tgt * TGT_STRIDE + ((kind == REG_MASK) ? MASK_SKEW : 0);
  endfunction

endpackage

// File: rtl/irqc_lowest_enc.sv
module irqc_lowest_enc #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);

  function automatic logic [IDX_W-1:0] first_set(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign idx_o   = first_set(vec_i);
  assign valid_o = |vec_i;

endmodule

// File: rtl/irqc_target.sv
module irqc_target #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cause_we,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] cause_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               valid_o
);

  logic [NUM_SRC-1:0] cause_q, mask_q;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic               enc_valid;

  function automatic logic [NUM_SRC-1:0] next_cause(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] ack,
    input logic [NUM_SRC-1:0] set
  );
    return (cur & ~ack) | set;
  endfunction

  assign ack_vec  = cause_we ? wdata : '0;
  assign pend_vec = cause_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= next_cause(cause_q, ack_vec, src_i);
      if (mask_we) mask_q <= wdata;
    end
  end

  irqc_lowest_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .vec_i   (pend_vec),
    .idx_o   (idx_o),
    .valid_o (enc_valid)
  );

  assign valid_o = enc_valid;
  assign irq_o   = |pend_vec;
  assign cause_o = cause_q;
  assign mask_o  = mask_q;

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & $past(src_i)) == $past(src_i)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |=> ((cause_q & $past(wdata & ~src_i)) == '0));

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_irq_matches_enc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == enc_valid);

  assert_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> (pend_vec[idx_o] &&
                   ((pend_vec & ~({NUM_SRC{1'b1}} << idx_o)) == '0)));

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  localparam int NUM_TGT = 2,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  output logic [NUM_TGT-1:0] irq_o,
  output logic [IDX_W-1:0]   tgt0_idx,
  output logic               tgt0_valid,
  output logic [IDX_W-1:0]   tgt1_idx,
  output logic               tgt1_valid
);
  import irqc_pkg::*;

  logic [NUM_TGT-1:0]               cause_hit, mask_hit;
  logic [NUM_TGT-1:0][NUM_SRC-1:0]  cause_v, mask_v;
  logic [NUM_TGT-1:0][IDX_W-1:0]    idx_v;
  logic [NUM_TGT-1:0]               valid_v;
  logic                             any_hit;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign cause_hit[t] = (addr == ADDR_W'(reg_offset(t, REG_CAUSE)));
    assign mask_hit[t]  = (addr == ADDR_W'(reg_offset(t, REG_MASK)));

    irqc_target #(.NUM_SRC(NUM_SRC)) u_tgt (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_i),
      .cause_we (wr_en & cause_hit[t]),
      .mask_we  (wr_en & mask_hit[t]),
      .wdata    (wdata),
      .cause_o  (cause_v[t]),
      .mask_o   (mask_v[t]),
      .irq_o    (irq_o[t]),
      .idx_o    (idx_v[t]),
      .valid_o  (valid_v[t])
    );
  end

  assign any_hit = |{cause_hit, mask_hit};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int t = 0; t < NUM_TGT; t++) begin
        if (cause_hit[t]) rdata = cause_v[t];
        if (mask_hit[t])  rdata = mask_v[t];
      end
    end
  end

  assign tgt0_idx   = idx_v[0];
  assign tgt0_valid = valid_v[0];
  assign tgt1_idx   = idx_v[1];
  assign tgt1_valid = valid_v[1];

  assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_hit) |-> (rdata == '0));

  assert_one_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_hit, mask_hit}));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (irq_o == '0 && !tgt0_valid && !tgt1_valid));

endmodule

// File: tb/sim_dual_irq_ctrl.sv
module sim_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq_o;
  logic [4:0]  tgt0_idx, tgt1_idx;
  logic        tgt0_valid, tgt1_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .tgt0_idx(tgt0_idx), .tgt0_valid(tgt0_valid),
    .tgt1_idx(tgt1_idx), .tgt1_valid(tgt1_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse_src(input logic [31:0] v);
    @(negedge clk); src_i = v;
    @(negedge clk); src_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h00, d); check("R1 cause0", d, 0);
    bus_read(8'h04, d); check("R1 mask0", d, 0);
    bus_read(8'h08, d); check("R1 cause1", d, 0);
    bus_read(8'h0C, d); check("R1 mask1", d, 0);
    check("R1 irq", {30'd0, irq_o}, 0);
    check("R1 valid", {30'd0, tgt1_valid, tgt0_valid}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    bus_write(8'h04, 32'hA5A5_0F0F);
    bus_write(8'h0C, 32'h1234_5678);
    bus_read(8'h04, d); check("R2 mask0 at 0x04", d, 32'hA5A5_0F0F);
    bus_read(8'h0C, d); check("R2 mask1 at 0x0C", d, 32'h1234_5678);
    bus_read(8'h00, d); check("R2 cause0 untouched", d, 0);
    bus_write(8'h04, 32'h0);
    bus_write(8'h0C, 32'h0);
    bus_read(8'h04, d); check("R9 mask0 replaced", d, 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    pulse_src(32'h8001_0010);
    bus_read(8'h00, d); check("R3 cause0 captured", d, 32'h8001_0010);
    bus_read(8'h08, d); check("R3 cause1 captured", d, 32'h8001_0010);
    check("R9 masked irq low", {30'd0, irq_o}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_write(8'h00, 32'h0000_0010);
    bus_read(8'h00, d); check("R4 cause0 bit4 cleared", d, 32'h8001_0000);
    bus_read(8'h08, d); check("R4 cause1 unaffected", d, 32'h8001_0010);
    bus_write(8'h00, 32'h0);
    bus_read(8'h00, d); check("R4 zero write keeps", d, 32'h8001_0000);
  endtask

  task automatic t_mask_irq();
    bus_write(8'h04, 32'h0001_0000);
    @(negedge clk); #1;
    check("R6 irq0 high irq1 low", {30'd0, irq_o}, 32'h1);
    check("R7 idx0", {27'd0, tgt0_idx}, 16);
    check("R7 valid0", {31'd0, tgt0_valid}, 1);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); #1;
    check("R6 both irq", {30'd0, irq_o}, 32'h3);
    check("R7 idx1 lowest", {27'd0, tgt1_idx}, 4);
    bus_write(8'h08, 32'h0001_0010);
    @(negedge clk); #1;
    check("R7 idx1 bit31", {27'd0, tgt1_idx}, 31);
    bus_write(8'h04, 32'h8000_0000);
    @(negedge clk); #1;
    check("R9 mask0 moved", {27'd0, tgt0_idx}, 31);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); src_i = 32'h0000_0080;
    bus_write(8'h00, 32'h0000_0080);
    bus_read(8'h00, d); check("R5 set beats clear", d & 32'h80, 32'h80);
    @(negedge clk); src_i = '0;
    bus_write(8'h00, 32'h0000_0080);
    bus_read(8'h00, d); check("R5 cleared after release", d & 32'h80, 0);
  endtask

  task automatic t_quiesce();
    logic [31:0] d;
    pulse_src(32'h0F00_0003);
    bus_write(8'h0C, 32'h0);
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h08, d); check("R8 cause1 empty", d, 0);
    check("R8 irq1 low", {31'd0, irq_o[1]}, 0);
    check("R8 valid1 low", {31'd0, tgt1_valid}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] c0, m0, c1, m1, d;
    bus_read(8'h00, c0); bus_read(8'h04, m0);
    bus_read(8'h08, c1); bus_read(8'h0C, m1);
    bus_read(8'h10, d); check("R2 unmapped read 0x10", d, 0);
    bus_read(8'h02, d); check("R2 unmapped read 0x02", d, 0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h06, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'hFFFF_FFFF);
    bus_read(8'h00, d); check("R2 cause0 after bad write", d, c0);
    bus_read(8'h04, d); check("R2 mask0 after bad write", d, m0);
    bus_read(8'h08, d); check("R2 cause1 after bad write", d, c1);
    bus_read(8'h0C, d); check("R2 mask1 after bad write", d, m1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_capture();
    t_w1c();
    t_mask_irq();
    t_set_wins();
    t_quiesce();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule